// File: doc/BRIEF.md
# VCO band calibration controller

This block chooses one of 128 coarse oscillator bands each time a new frequency has been programmed. A start pulse arrives after the final divider write. The controller then drives a trial band code to the oscillator. It counts divided-oscillator edges while a fixed number of reference ticks go by, and compares that count with a target count. Seven such measurements resolve the code one bit at a time, from the most significant bit down. An eighth window follows, in which the winning code is held while the loop settles. A whole calibration therefore always lasts eight windows of 640 reference ticks, which is 5120 comparison cycles.

Software can bypass the search. With the manual-select input high, a start pulse loads a supplied band code at once and reports completion on the next cycle.

Outside calibration, the same edge counter serves as a built-in frequency meter. Software enables it, clears it and picks an integration interval of 256, 512, 1024 or 2048 reference ticks. At the end of the interval the counter freezes and a done flag rises. The count saturates at its top value. All inputs, including the oscillator and reference ticks, are single-cycle qualifiers in the block's clock domain.

Top module: `vco_band_cal`

## Requirements
- R1: After reset the band output is 0x20, and busy, cal_done, bist_done and count are all 0.
- R2: A start pulse with manual_sel low raises busy on the next cycle. The trial band is then 0x40: bit 6 set, all other bits clear.
- R3: At the end of each search window, the bit under test stays set if the window's edge count is below target, and is cleared otherwise; the next lower bit is then set as the new trial. With oscillator frequency rising with band code, the final band is the largest code whose count is below target, or 0 if no code qualifies.
- R4: With a reference tick on every clock, cal_done pulses for one cycle exactly 8 × 640 = 5120 clock edges after the edge that sampled start, and busy is low in that cycle.
- R5: A start pulse with manual_sel high loads manual_band onto the band output at the next edge and pulses cal_done in that same cycle. Busy stays low.
- R6: A start pulse that arrives while busy restarts the search from trial code 0x40. Only one cal_done follows, 5120 edges after the last start, carrying the result for the target in force during that run.
- R7: When bist_en is high, the block is idle and bist_clr has been pulsed, the counter counts oscillator ticks while 256 << bist_interval reference ticks elapse (codes 0, 1, 2, 3 give 256, 512, 1024, 2048). The count includes the tick in the final cycle. bist_done then rises and count holds its value.
- R8: The counter saturates at 0xFFFF and does not wrap.
- R9: bist_clr clears count and bist_done even when bist_en is low. While bist_en is low the counter does not count and bist_done does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Calibration request pulse, issued after the final divider write |
| manual_sel | input | 1 | 0 = search for the band, 1 = load manual_band |
| manual_band | input | 7 | Band code used in manual mode |
| target | input | 16 | Edge count expected from the oscillator over one search window |
| osc_tick | input | 1 | One-cycle pulse per divided-oscillator edge |
| ref_tick | input | 1 | One-cycle pulse per reference comparison cycle |
| bist_en | input | 1 | Frequency-meter enable |
| bist_clr | input | 1 | Frequency-meter clear pulse |
| bist_interval | input | 2 | Frequency-meter interval code: 256 << code ticks |
| band | output | 7 | Band code driven to the oscillator |
| busy | output | 1 | Search or settle in progress |
| cal_done | output | 1 | One-cycle pulse when a calibration completes |
| count | output | 16 | Shared edge counter value |
| bist_done | output | 1 | Frequency-meter interval finished |

## Verification
The properties assume that start, bist_clr, osc_tick and ref_tick are already synchronous to clk. They also assume that target and bist_interval are held steady for the whole of any window that uses them. The bench changes all of these only between runs, and always on the falling clock edge. For the search itself, the bench models an oscillator whose edge rate grows linearly with the band code. It uses a phase accumulator that yields exactly five edges per window for each step of code. Every target sits midway between two adjacent bands' counts, so the expected band is exact.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SEARCH = 2'd1,
    CAL_SETTLE = 2'd2
  } cal_state_e;

  // Increment by one unless the value already sits at its ceiling.
  function automatic logic [31:0] sat_add1(input logic [31:0] cnt,
                                           input logic        inc,
                                           input logic [31:0] ceiling);
    if (inc && (cnt < ceiling)) return cnt + 32'd1;
    return cnt;
  endfunction

  // Meter interval length in reference ticks for a 2-bit code.
  function automatic logic [31:0] bist_window(input logic [31:0] base,
                                              input logic [1:0]  code);
    return base << code;
  endfunction

  // One successive-approximation step: decide the bit under test,
  // then raise the next lower bit as the following trial.
  function automatic logic [31:0] sar_update(input logic [31:0] code,
                                             input int          idx,
                                             input logic        below);
    logic [31:0] r;
    r      = code;
    r[idx] = below;
    if (idx > 0) r[idx-1] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/vcal_edge_cnt.sv
module vcal_edge_cnt
  import vcal_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             osc_tick,
  input  logic             ref_tick,
  input  logic [WIN_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             win_end
);

  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 64'd1);

  logic [WIN_W-1:0] win_cnt;

  always_comb begin
    count_nxt = CNT_W'(sat_add1(32'(count), osc_tick, CNT_MAX));
    win_end   = run & ref_tick & (win_cnt == (limit - WIN_W'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      win_cnt <= '0;
    end else if (clr) begin
      count   <= '0;
      win_cnt <= '0;
    end else if (run) begin
      count <= count_nxt;
      if (ref_tick) win_cnt <= win_end ? '0 : (win_cnt + WIN_W'(1));
    end
  end

endmodule

// File: rtl/vcal_sar.sv
module vcal_sar
  import vcal_pkg::*;
#(
  parameter int BAND_W   = 7,
  parameter int CNT_W    = 16,
  parameter int BAND_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              manual_sel,
  input  logic [BAND_W-1:0] manual_band,
  input  logic [CNT_W-1:0]  target,
  input  logic              win_end,
  input  logic [CNT_W-1:0]  count_nxt,
  output logic [BAND_W-1:0] band,
  output logic              busy,
  output logic              cal_done,
  output logic              cnt_clr,
  output logic              start_auto,
  output logic              step_evt,
  output logic              settle_end
);

  localparam int IDX_W = (BAND_W > 2) ? $clog2(BAND_W) : 1;
  localparam logic [BAND_W-1:0] FIRST_TRIAL = BAND_W'(1 << (BAND_W - 1));

  cal_state_e       state;
  logic [IDX_W-1:0] bit_idx;
  logic             start_man;
  logic             below;

  always_comb begin
    start_auto = start & ~manual_sel;
    start_man  = start & manual_sel;
    busy       = (state != CAL_IDLE);
    step_evt   = (state == CAL_SEARCH) & win_end;
    settle_end = (state == CAL_SETTLE) & win_end;
    below      = (count_nxt < target);
    cnt_clr    = start_auto | (busy & (win_end | start_man));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= CAL_IDLE;
      band     <= BAND_W'(BAND_RST);
      bit_idx  <= '0;
      cal_done <= 1'b0;
    end else begin
      cal_done <= 1'b0;
      if (start_man) begin
        band     <= manual_band;
        state    <= CAL_IDLE;
        cal_done <= 1'b1;
      end else if (start_auto) begin
        band    <= FIRST_TRIAL;
        bit_idx <= IDX_W'(BAND_W - 1);
        state   <= CAL_SEARCH;
      end else if (step_evt) begin
        band <= BAND_W'(sar_update(32'(band), int'(bit_idx), below));
        if (bit_idx == '0) state <= CAL_SETTLE;
        else               bit_idx <= bit_idx - IDX_W'(1);
      end else if (settle_end) begin
        state    <= CAL_IDLE;
        cal_done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vcal_bist.sv
module vcal_bist
  import vcal_pkg::*;
#(
  parameter int WIN_W     = 12,
  parameter int BIST_BASE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_en,
  input  logic             bist_clr,
  input  logic [1:0]       bist_interval,
  input  logic             busy,
  input  logic             cal_start,
  input  logic             win_end,
  output logic             run,
  output logic             clr_req,
  output logic [WIN_W-1:0] limit,
  output logic             bist_done
);

  always_comb begin
    run     = bist_en & ~bist_done & ~busy;
    clr_req = bist_clr & ~busy;
    limit   = WIN_W'(bist_window(32'(BIST_BASE), bist_interval));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bist_done <= 1'b0;
    else if (cal_start)        bist_done <= 1'b0;
    else if (clr_req)          bist_done <= 1'b0;
    else if (run && win_end)   bist_done <= 1'b1;
  end

endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
  import vcal_pkg::*;
#(
  parameter int BAND_W    = 7,
  parameter int CNT_W     = 16,
  parameter int CAL_WIN   = 640,
  parameter int BIST_BASE = 256,
  parameter int BAND_RST  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              manual_sel,
  input  logic [BAND_W-1:0] manual_band,
  input  logic [CNT_W-1:0]  target,
  input  logic              osc_tick,
  input  logic              ref_tick,
  input  logic              bist_en,
  input  logic              bist_clr,
  input  logic [1:0]        bist_interval,
  output logic [BAND_W-1:0] band,
  output logic              busy,
  output logic              cal_done,
  output logic [CNT_W-1:0]  count,
  output logic              bist_done
);

  localparam int BIST_MAX = BIST_BASE * 8;
  localparam int WIN_MAX  = (CAL_WIN > BIST_MAX) ? CAL_WIN : BIST_MAX;
  localparam int WIN_W    = $clog2(WIN_MAX + 1);

  logic [CNT_W-1:0] count_nxt;
  logic [WIN_W-1:0] limit;
  logic [WIN_W-1:0] bist_limit;
  logic             win_end;
  logic             sar_clr;
  logic             bist_clr_req;
  logic             bist_run;
  logic             start_auto;
  logic             step_evt;
  logic             settle_end;
  logic             cnt_clr;
  logic             cnt_run;

  always_comb begin
    limit   = busy ? WIN_W'(CAL_WIN) : bist_limit;
    cnt_clr = sar_clr | bist_clr_req;
    cnt_run = busy | bist_run;
  end

  vcal_edge_cnt #(.CNT_W(CNT_W), .WIN_W(WIN_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .run       (cnt_run),
    .osc_tick  (osc_tick),
    .ref_tick  (ref_tick),
    .limit     (limit),
    .count     (count),
    .count_nxt (count_nxt),
    .win_end   (win_end)
  );

  vcal_sar #(.BAND_W(BAND_W), .CNT_W(CNT_W), .BAND_RST(BAND_RST)) sar_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .manual_sel  (manual_sel),
    .manual_band (manual_band),
    .target      (target),
    .win_end     (win_end),
    .count_nxt   (count_nxt),
    .band        (band),
    .busy        (busy),
    .cal_done    (cal_done),
    .cnt_clr     (sar_clr),
    .start_auto  (start_auto),
    .step_evt    (step_evt),
    .settle_end  (settle_end)
  );

  vcal_bist #(.WIN_W(WIN_W), .BIST_BASE(BIST_BASE)) bist_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bist_en       (bist_en),
    .bist_clr      (bist_clr),
    .bist_interval (bist_interval),
    .busy          (busy),
    .cal_start     (start_auto),
    .win_end       (win_end),
    .run           (bist_run),
    .clr_req       (bist_clr_req),
    .limit         (bist_limit),
    .bist_done     (bist_done)
  );

endmodule

// File: rtl/vco_band_cal_chk.sv
module vco_band_cal_chk #(
  parameter int BAND_W = 7,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              manual_sel,
  input logic [BAND_W-1:0] manual_band,
  input logic [BAND_W-1:0] band,
  input logic              busy,
  input logic              cal_done,
  input logic [CNT_W-1:0]  count,
  input logic              bist_done,
  input logic              step_evt,
  input logic              settle_end
);

  // R2
  auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !manual_sel) |=> (busy && band == BAND_W'(1 << (BAND_W - 1))));

  // R5
  manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && manual_sel) |=> (cal_done && !busy && band == $past(manual_band)));

  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cal_done);

  // R4
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> !busy);

  // R4
  settle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_end && !start) |=> cal_done);

  // R3
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(step_evt) && !$past(start)) |-> $stable(band));

  // R7
  bist_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_done && $past(bist_done)) |-> $stable(count));

endmodule

bind vco_band_cal vco_band_cal_chk #(.BAND_W(BAND_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .manual_sel  (manual_sel),
  .manual_band (manual_band),
  .band        (band),
  .busy        (busy),
  .cal_done    (cal_done),
  .count       (count),
  .bist_done   (bist_done),
  .step_evt    (step_evt),
  .settle_end  (settle_end)
);

// File: tb/vco_band_cal_tb_top.sv
module vco_band_cal_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BAND_W     = 7;
  localparam int CNT_W      = 16;
  localparam int CAL_WIN    = 640;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              manual_sel = 1'b0;
  logic [BAND_W-1:0] manual_band = '0;
  logic [CNT_W-1:0]  target = '0;
  logic              osc_tick = 1'b0;
  logic              ref_tick = 1'b0;
  logic              bist_en = 1'b0;
  logic              bist_clr = 1'b0;
  logic [1:0]        bist_interval = 2'd0;
  logic [BAND_W-1:0] band;
  logic              busy;
  logic              cal_done;
  logic [CNT_W-1:0]  count;
  logic              bist_done;

  vco_band_cal dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .manual_sel(manual_sel),
    .manual_band(manual_band), .target(target), .osc_tick(osc_tick),
    .ref_tick(ref_tick), .bist_en(bist_en), .bist_clr(bist_clr),
    .bist_interval(bist_interval), .band(band), .busy(busy),
    .cal_done(cal_done), .count(count), .bist_done(bist_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int start_cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Stimulus models: oscillator edge rate grows with band, reference divided
  bit osc_mode = 0;
  bit osc_const = 0;
  int ref_div = 1;
  int ref_ph = 0;
  int acc = 0;

  always @(negedge clk) begin
    if (!osc_mode) begin
      acc = acc + int'(band) + 1;
      if (acc >= 128) begin acc = acc - 128; osc_tick = 1'b1; end
      else osc_tick = 1'b0;
    end else begin
      osc_tick = osc_const;
    end
    if (ref_div <= 1) ref_tick = 1'b1;
    else begin
      ref_ph = (ref_ph + 1) % ref_div;
      ref_tick = (ref_ph == 0);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Each oscillator code m = band+1 yields 5*m edges per 640-tick window.
  function automatic int exp_band(int t);
    int b;
    b = (t + 4) / 5 - 2;
    if (b < 0) b = 0;
    if (b > 127) b = 127;
    return b;
  endfunction

  typedef struct {
    int    band;
    int    lat;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  exp_t drop_e;

  // Monitor: every completion is matched against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cal_done) begin
      if (exp_q.size() == 0) chk("R6", "unexpected cal_done", 1, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(mon_e.tag, "band", int'(band), mon_e.band);
        chk(mon_e.tag, "latency", cyc - start_cyc, mon_e.lat);
        chk(mon_e.tag, "busy at done", int'(busy), 0);
      end
    end
  end

  task automatic cal_auto(int t, bit restart, string tag);
    @(negedge clk);
    target = CNT_W'(t);
    manual_sel = 1'b0;
    start = 1'b1;
    start_cyc = cyc + 1;
    if (restart && exp_q.size() > 0) drop_e = exp_q.pop_back();
    exp_q.push_back('{exp_band(t), 8 * CAL_WIN, tag});
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "first trial band", int'(band), 64);
  endtask

  task automatic cal_manual(int v, bit abort);
    @(negedge clk);
    manual_sel = 1'b1;
    manual_band = BAND_W'(v);
    start = 1'b1;
    start_cyc = cyc + 1;
    if (abort && exp_q.size() > 0) drop_e = exp_q.pop_back();
    exp_q.push_back('{v, 0, "R5"});
    @(negedge clk);
    start = 1'b0;
    manual_sel = 1'b0;
    chk("R5", "busy after manual start", int'(busy), 0);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin @(negedge clk); n++; end
    chk("R4", "completion seen", exp_q.size(), 0);
  endtask

  task automatic bist_run(int code, bit oc, int rdiv, int exp, string tag);
    int n = 0;
    @(negedge clk);
    osc_mode = 1; osc_const = oc; ref_div = rdiv; bist_interval = 2'(code);
    @(negedge clk);
    bist_en = 1'b1; bist_clr = 1'b1;
    @(negedge clk);
    bist_clr = 1'b0;
    while (!bist_done && n < 100000) begin @(negedge clk); n++; end
    chk(tag, "meter done", int'(bist_done), 1);
    chk(tag, "meter count", int'(count), exp);
    repeat (16) @(negedge clk);
    chk(tag, "meter count held", int'(count), exp);
    bist_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk("WATCHDOG", "run finished", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "reset band", int'(band), 32);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset cal_done", int'(cal_done), 0);
    chk("R1", "reset count", int'(count), 0);
    chk("R1", "reset bist_done", int'(bist_done), 0);

    // R3 and R4 across several targets, including the range ends
    cal_auto(253, 0, "R3"); drain();
    cal_auto(8, 0, "R3"); drain();
    cal_auto(643, 0, "R3"); drain();
    cal_auto(0, 0, "R3"); drain();
    cal_auto(65535, 0, "R3"); drain();
    cal_auto(453, 0, "R4"); drain();

    // R6: restart in mid search
    cal_auto(253, 0, "R6");
    repeat (1500) @(negedge clk);
    cal_auto(453, 1, "R6");
    drain();

    // R5: manual load when idle, and as an abort of a running search
    cal_manual(85, 0); drain();
    cal_auto(253, 0, "R6");
    repeat (100) @(negedge clk);
    cal_manual(17, 1); drain();

    // R7 and R8: frequency meter
    bist_run(0, 1, 1, 256, "R7");
    bist_run(1, 1, 1, 512, "R7");
    bist_run(2, 0, 1, 0, "R7");
    bist_run(3, 1, 33, 65535, "R8");

    // R9: clear without enable, then no counting while disabled
    @(negedge clk);
    bist_en = 1'b0; bist_clr = 1'b1; osc_const = 1; ref_div = 1; bist_interval = 2'd0;
    @(negedge clk);
    bist_clr = 1'b0;
    chk("R9", "count cleared", int'(count), 0);
    chk("R9", "done cleared", int'(bist_done), 0);
    repeat (600) @(negedge clk);
    chk("R9", "count while disabled", int'(count), 0);
    chk("R9", "done while disabled", int'(bist_done), 0);

    finish_run();
  end

endmodule